// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block sits between a simple single-request port and one DRAM bank. It accepts a read or write with a flat address. The upper address bits select a row and the lower bits select a column. The block turns each request into the bank's command sequence: open a row, perform the column access, and close the row when a different row is needed. Row and column addresses leave over one shared address bus, in separate command cycles.

The block follows an open-page policy. After a column access the row stays latched in the bank. A later request to the same row goes straight to its column command. A request to another row first closes the open row, then opens the new one. Each phase has a cycle latency set by a parameter and counted down before the next command. Read data comes back on a one-cycle valid strobe once the column latency has run.

Top module: `dram_bank_seq`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `dram_cmd` is NOP, `rd_valid` is 0 and no row is open.
- R2: `dram_cmd` encodes NOP=0, ACT=1, RD=2, WR=3, PRE=4. The row is `req_addr[ROW_W+COL_W-1:COL_W]` and the column is `req_addr[COL_W-1:0]`. On ACT, `dram_addr` carries the row, and on RD/WR it carries the column, zero-extended. On PRE, `dram_addr` has no meaning.
- R3: When no row is open, an accepted request issues ACT in the cycle after acceptance, with no PRE before it.
- R4: When the requested row is already open, RD or WR is issued in the cycle after acceptance, with no ACT or PRE.
- R5: When another row is open, the block issues PRE in the cycle after acceptance, then ACT T_RP cycles after PRE.
- R6: A column command follows its ACT by exactly T_RCD cycles.
- R7: For a read, `rd_valid` is high for exactly one cycle, T_CL cycles after the RD command. `rd_data` carries `dram_rdata` as sampled in the cycle before.
- R8: A WR command presents the request's write data on `dram_wdata` in the same cycle, and a write never raises `rd_valid`.
- R9: `req_ready` is low from the cycle after acceptance until the column phase ends. It rises in the same cycle as the read strobe, and `dram_cmd` is NOP whenever `req_ready` is high.
- R10: A `req_valid` presented while `req_ready` is low is ignored. It changes neither the command stream nor the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat address, row in the upper bits |
| req_wdata | input | DQ_W | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DQ_W | Read data |
| dram_cmd | output | 3 | Bank command code |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_wdata | output | DQ_W | Data sent with WR |
| dram_rdata | input | DQ_W | Data returned by the bank |

## Verification
The bench builds the block with ROW_W=4, COL_W=3 and DQ_W=16. It sets the three latencies to different values: T_RCD=3, T_CL=4 and T_RP=2. With distinct latencies, a swapped phase counter shifts a command by a cycle and gets caught. The narrow row field makes hits, misses, and the first and last row and column easy to reach. A behavioural bank memory in the bench answers RD commands, so written data is traced back through the read strobe.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_OPEN,
        ST_COL,
        ST_PRE
    } seq_state_e;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } bank_cmd_e;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dbs_phase_timer.sv
// Down-counter shared by all phases; busy while a phase still has cycles left.
module dbs_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/dbs_row_tracker.sv
// Remembers which row, if any, is latched in the bank.
module dbs_row_tracker #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set,
    input  logic             clr,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] probe_row,
    output logic             hit
);
    logic             valid_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            row_q   <= '0;
        end else if (set) begin
            valid_q <= 1'b1;
            row_q   <= set_row;
        end else if (clr) begin
            valid_q <= 1'b0;
        end
    end

    assign hit = valid_q && (row_q == probe_row);
endmodule

// File: rtl/dbs_rd_capture.sv
// Latches bank read data at the close of a read column phase.
module dbs_rd_capture #(
    parameter int DQ_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  logic [DQ_W-1:0] bank_data,
    output logic            strobe,
    output logic [DQ_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe <= 1'b0;
            data   <= '0;
        end else begin
            strobe <= fire;
            if (fire)
                data <= bank_data;
        end
    end
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
    import dbs_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 8,
    parameter int DQ_W  = 8,
    parameter int T_RCD = 4,
    parameter int T_CL  = 4,
    parameter int T_RP  = 4,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int BUS_W  = max_i(ROW_W, COL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic [2:0]        dram_cmd,
    output logic [BUS_W-1:0]  dram_addr,
    output logic [DQ_W-1:0]   dram_wdata,
    input  logic [DQ_W-1:0]   dram_rdata
);
    localparam int MAX_T = max_i(max_i(T_RCD, T_CL), T_RP);
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_CL  = CNT_W'(T_CL - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);

    typedef struct packed {
        logic             we;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [DQ_W-1:0]  wdata;
    } access_t;

    seq_state_e       state_q, nxt_state;
    bank_cmd_e        cmd_q, nxt_cmd;
    logic [BUS_W-1:0] addr_q, nxt_addr;
    logic [DQ_W-1:0]  wdata_q, nxt_wdata;
    access_t          in_req, pend_q;
    logic             accept;
    logic             tmr_load, tmr_busy;
    logic [CNT_W-1:0] tmr_val;
    logic             row_set, row_clr, row_hit;
    logic [ROW_W-1:0] row_set_val;
    logic             rd_fire;

    assign in_req.we    = req_we;
    assign in_req.row   = req_addr[ADDR_W-1:COL_W];
    assign in_req.col   = req_addr[COL_W-1:0];
    assign in_req.wdata = req_wdata;

    assign req_ready = (state_q == ST_IDLE) || (state_q == ST_OPEN);
    assign accept    = req_valid && req_ready;

    dbs_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .busy     (tmr_busy)
    );

    dbs_row_tracker #(.ROW_W(ROW_W)) rows_i (
        .clk       (clk),
        .rst       (rst),
        .set       (row_set),
        .clr       (row_clr),
        .set_row   (row_set_val),
        .probe_row (in_req.row),
        .hit       (row_hit)
    );

    dbs_rd_capture #(.DQ_W(DQ_W)) rdcap_i (
        .clk       (clk),
        .rst       (rst),
        .fire      (rd_fire),
        .bank_data (dram_rdata),
        .strobe    (rd_valid),
        .data      (rd_data)
    );

    always_comb begin
        nxt_state   = state_q;
        nxt_cmd     = CMD_NOP;
        nxt_addr    = addr_q;
        nxt_wdata   = wdata_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        row_set     = 1'b0;
        row_clr     = 1'b0;
        row_set_val = pend_q.row;
        rd_fire     = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                nxt_state   = ST_ACT;
                nxt_cmd     = CMD_ACT;
                nxt_addr    = BUS_W'(in_req.row);
                tmr_load    = 1'b1;
                tmr_val     = LD_RCD;
                row_set     = 1'b1;
                row_set_val = in_req.row;
            end
            ST_OPEN: if (req_valid) begin
                if (row_hit) begin
                    nxt_state = ST_COL;
                    nxt_cmd   = in_req.we ? CMD_WR : CMD_RD;
                    nxt_addr  = BUS_W'(in_req.col);
                    nxt_wdata = in_req.wdata;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_CL;
                end else begin
                    nxt_state = ST_PRE;
                    nxt_cmd   = CMD_PRE;
                    nxt_addr  = '0;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_RP;
                    row_clr   = 1'b1;
                end
            end
            ST_PRE: if (!tmr_busy) begin
                nxt_state = ST_ACT;
                nxt_cmd   = CMD_ACT;
                nxt_addr  = BUS_W'(pend_q.row);
                tmr_load  = 1'b1;
                tmr_val   = LD_RCD;
                row_set   = 1'b1;
            end
            ST_ACT: if (!tmr_busy) begin
                nxt_state = ST_COL;
                nxt_cmd   = pend_q.we ? CMD_WR : CMD_RD;
                nxt_addr  = BUS_W'(pend_q.col);
                nxt_wdata = pend_q.wdata;
                tmr_load  = 1'b1;
                tmr_val   = LD_CL;
            end
            ST_COL: if (!tmr_busy) begin
                nxt_state = ST_OPEN;
                rd_fire   = !pend_q.we;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_NOP;
            addr_q  <= '0;
            wdata_q <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= nxt_state;
            cmd_q   <= nxt_cmd;
            addr_q  <= nxt_addr;
            wdata_q <= nxt_wdata;
            if (accept)
                pend_q <= in_req;
        end
    end

    assign dram_cmd   = cmd_q;
    assign dram_addr  = addr_q;
    assign dram_wdata = wdata_q;
endmodule

// File: rtl/dram_bank_seq_chk.sv
module dram_bank_seq_chk
    import dbs_pkg::*;
#(
    parameter int T_RCD = 4,
    parameter int T_CL  = 4,
    parameter int T_RP  = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       rd_valid,
    input logic [2:0] dram_cmd
);
    logic       bank_open_q;
    logic [2:0] last_q;
    logic [7:0] gap_q;
    logic       is_cmd;

    assign is_cmd = (dram_cmd != 3'(CMD_NOP));

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_open_q <= 1'b0;
            last_q      <= 3'(CMD_NOP);
            gap_q       <= '0;
        end else begin
            if (dram_cmd == 3'(CMD_ACT)) bank_open_q <= 1'b1;
            if (dram_cmd == 3'(CMD_PRE)) bank_open_q <= 1'b0;
            if (is_cmd) begin
                last_q <= dram_cmd;
                gap_q  <= 8'd1;
            end else if (gap_q != 8'hFF) begin
                gap_q <= gap_q + 8'd1;
            end
        end
    end

    p_act_closed_r3: assert property (@(posedge clk) disable iff (rst)
        dram_cmd == 3'(CMD_ACT) |-> !bank_open_q);
    p_pre_open_r5: assert property (@(posedge clk) disable iff (rst)
        dram_cmd == 3'(CMD_PRE) |-> bank_open_q);
    p_col_open_r6: assert property (@(posedge clk) disable iff (rst)
        (dram_cmd == 3'(CMD_RD) || dram_cmd == 3'(CMD_WR)) |-> bank_open_q);
    p_gap_act_r6: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && last_q == 3'(CMD_ACT)) |-> int'(gap_q) >= T_RCD);
    p_gap_pre_r5: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && last_q == 3'(CMD_PRE)) |-> int'(gap_q) >= T_RP);
    p_gap_col_r7: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && (last_q == 3'(CMD_RD) || last_q == 3'(CMD_WR))) |-> int'(gap_q) >= T_CL);
    p_rdv_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
    p_ready_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !is_cmd);
    p_rdv_ready_r9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> req_ready);
endmodule

bind dram_bank_seq dram_bank_seq_chk #(
    .T_RCD (T_RCD),
    .T_CL  (T_CL),
    .T_RP  (T_RP)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .dram_cmd  (dram_cmd)
);

// File: tb/dram_bank_seq_tb_top.sv
module dram_bank_seq_tb_top;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 3;
    localparam int DQ_W   = 16;
    localparam int T_RCD  = 3;
    localparam int T_CL   = 4;
    localparam int T_RP   = 2;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int NCOL   = 1 << COL_W;
    localparam int NWORD  = 1 << ADDR_W;
    localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DQ_W-1:0]   req_wdata = '0;
    logic              rd_valid;
    logic [DQ_W-1:0]   rd_data;
    logic [2:0]        dram_cmd;
    logic [BUS_W-1:0]  dram_addr;
    logic [DQ_W-1:0]   dram_wdata;
    logic [DQ_W-1:0]   dram_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural bank (driven by observed commands) and reference contents
    logic [DQ_W-1:0] dmem [NWORD];
    logic [DQ_W-1:0] ref_mem [NWORD];
    int  dm_row = 0;
    bit  m_open = 0;
    int  m_row = 0;

    always #4 clk = ~clk;

    dram_bank_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
        .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP)
    ) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_cmd(dram_cmd), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bank_model();
        if (dram_cmd == 3'(C_ACT)) dm_row = int'(dram_addr);
        if (dram_cmd == 3'(C_RD))  dram_rdata = dmem[dm_row * NCOL + int'(dram_addr)];
        if (dram_cmd == 3'(C_WR))  dmem[dm_row * NCOL + int'(dram_addr)] = dram_wdata;
    endtask

    // one request; stray >= 0 pulses an extra req_valid in that busy cycle
    task automatic access(input bit we, input int row, input int col,
                          input logic [DQ_W-1:0] wd, input int stray);
        int    e_cmd[$];
        int    e_adr[$];
        string e_tag[$];
        string col_tag;
        while (req_ready !== 1'b1) @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = ADDR_W'(row * NCOL + col);
        req_wdata = wd;
        col_tag   = "R4";
        if (!m_open) begin
            e_cmd.push_back(C_ACT); e_adr.push_back(row); e_tag.push_back("R3");
            for (int k = 1; k < T_RCD; k++) begin e_cmd.push_back(C_NOP); e_adr.push_back(0); e_tag.push_back("R6"); end
            col_tag = "R6";
        end else if (m_row != row) begin
            e_cmd.push_back(C_PRE); e_adr.push_back(0); e_tag.push_back("R5");
            for (int k = 1; k < T_RP; k++) begin e_cmd.push_back(C_NOP); e_adr.push_back(0); e_tag.push_back("R5"); end
            e_cmd.push_back(C_ACT); e_adr.push_back(row); e_tag.push_back("R5");
            for (int k = 1; k < T_RCD; k++) begin e_cmd.push_back(C_NOP); e_adr.push_back(0); e_tag.push_back("R6"); end
            col_tag = "R6";
        end
        e_cmd.push_back(we ? C_WR : C_RD); e_adr.push_back(col); e_tag.push_back(col_tag);
        for (int k = 1; k < T_CL; k++) begin e_cmd.push_back(C_NOP); e_adr.push_back(0); e_tag.push_back("R7"); end
        m_open = 1;
        m_row  = row;
        if (we) ref_mem[row * NCOL + col] = wd;
        for (int i = 0; i < e_cmd.size(); i++) begin
            string t;
            @(negedge clk);
            req_valid = 1'b0;
            t = (stray >= 0 && i > stray) ? "R10" : e_tag[i];
            check(dram_cmd == 3'(e_cmd[i]), t, dram_cmd, e_cmd[i]);
            if (e_cmd[i] == C_ACT || e_cmd[i] == C_RD || e_cmd[i] == C_WR)
                check(dram_addr == BUS_W'(e_adr[i]), "R2", dram_addr, e_adr[i]);
            if (e_cmd[i] == C_WR)
                check(dram_wdata == wd, "R8", dram_wdata, wd);
            check(req_ready == 1'b0, "R9", req_ready, 0);
            check(rd_valid == 1'b0, we ? "R8" : "R7", rd_valid, 0);
            bank_model();
            if (i == stray) begin
                req_valid = 1'b1;
                req_we    = ~we;
                req_addr  = ADDR_W'(((row + 3) % (1 << ROW_W)) * NCOL + ((col + 1) % NCOL));
                req_wdata = ~wd;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b1, "R9", req_ready, 1);
        check(dram_cmd == 3'(C_NOP), "R9", dram_cmd, C_NOP);
        if (we) begin
            check(rd_valid == 1'b0, "R8", rd_valid, 0);
        end else begin
            check(rd_valid == 1'b1, "R7", rd_valid, 1);
            check(rd_data == ref_mem[row * NCOL + col], (stray >= 0) ? "R10" : "R7",
                  rd_data, ref_mem[row * NCOL + col]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NWORD; i++) begin
            dmem[i]    = DQ_W'(i * 16'h0137 ^ 16'h5A5A);
            ref_mem[i] = DQ_W'(i * 16'h0137 ^ 16'h5A5A);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", req_ready, 1);
        check(dram_cmd == 3'(C_NOP), "R1", dram_cmd, C_NOP);
        check(rd_valid == 1'b0, "R1", rd_valid, 0);

        access(0, 5, 2, '0, -1);          // R3 closed bank, read
        access(1, 5, 2, 16'hBEEF, -1);    // R4 hit write, R8
        access(0, 5, 2, '0, -1);          // R4 hit read of written value, R7
        access(1, 9, 7, 16'h1234, -1);    // R5 miss write
        access(0, 5, 2, '0, 2);           // R5 miss read with stray valid, R10
        access(0, 9, 7, '0, 1);           // miss again, stray in PRE phase, R10
        access(0, 15, 0, '0, -1);         // boundary row, first column
        access(0, 15, 7, '0, -1);         // boundary column, hit
        access(1, 0, 0, 16'h0001, -1);    // row 0 col 0
        access(0, 0, 0, '0, -1);
        for (int c = 0; c < 4; c++) access(1, 0, c + 3, DQ_W'(16'hA000 + c), -1);
        for (int c = 0; c < 4; c++) access(0, 0, c + 3, '0, -1);
        access(0, 9, 7, '0, -1);          // earlier write still present

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule